// File: doc/BRIEF.md
# Digital Loopback Mixer with Saturation

This block feeds the converted input (capture) audio back into the output (playback) path. Each playback sample pair that arrives is summed with an attenuated copy of the most recent capture sample pair. The sum is clamped to the signed 16-bit range and then presented to the output converters. A single enable turns the feedback path on or off for both channels at once. When the path is off, the playback samples pass through unchanged.

Attenuation is set in 1.5 dB steps by a 6-bit code. In shared mode one code sets the gain of both channels. In split mode that same code sets the left channel only, and a second code sets the right channel. A capture stream flagged as mono has its left sample routed into both output channels. The block adds one register stage. It is paced entirely by the playback strobe.

Top module: `lbm_loopback_mixer`

## Requirements
- R1: After synchronous reset, `dac_valid` is 0, `dac_left` and `dac_right` are 0, and the held capture pair is 0.
- R2: `dac_valid` is high in exactly the cycle after a cycle with `pb_valid` high. It is low otherwise. `dac_left` and `dac_right` change only in the cycle that follows `pb_valid`.
- R3: With `lb_enable` low, `dac_left`/`dac_right` equal `pb_left`/`pb_right` bit for bit, whatever the capture inputs or codes are.
- R4: With `lb_enable` high, each output equals clamp(playback + atten(capture, code)). The sum is formed at 17-bit signed precision.
- R5: atten(x, c) takes q = c[5:2] and r = c[1:0], then sets s = x >>> q (arithmetic shift). By r, the result is: r=0 gives s; r=1 gives s - (s>>>3) - (s>>>5); r=2 gives (s>>>1) + (s>>>3) + (s>>>4) + (s>>>6); r=3 gives (s>>>1) + (s>>>4) + (s>>>5). Code 0 is therefore unity gain.
- R6: With `split_mode` low, `atten_main` sets both channels and `atten_aux` has no effect on either output.
- R7: With `split_mode` high, `atten_main` sets the left channel and `atten_aux` sets the right channel. `lb_enable` still gates both channels.
- R8: A capture strobe with `cap_mono` high stores `cap_left` for both channels. `cap_right` is ignored, so the mono sample is added into both outputs.
- R9: Sums above 32767 yield 32767 (0x7FFF). Sums below -32768 yield -32768 (0x8000).
- R10: If `cap_valid` is high in the same cycle as `pb_valid`, that new capture pair is mixed. Otherwise the most recently stored capture pair is mixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture sample pair strobe |
| cap_mono | input | 1 | Capture pair is mono (left carries the sample) |
| cap_left | input | 16 | Signed left capture sample |
| cap_right | input | 16 | Signed right capture sample |
| pb_valid | input | 1 | Playback sample pair strobe |
| pb_left | input | 16 | Signed left playback sample |
| pb_right | input | 16 | Signed right playback sample |
| lb_enable | input | 1 | Loopback path enable, both channels |
| split_mode | input | 1 | Separate left/right attenuation |
| atten_main | input | 6 | Attenuation code: both channels, or left in split mode |
| atten_aux | input | 6 | Attenuation code for right in split mode |
| dac_valid | output | 1 | Output pair strobe |
| dac_left | output | 16 | Signed left output sample |
| dac_right | output | 16 | Signed right output sample |

## Verification
The bench sweeps all 64 attenuation codes against extreme and ordinary samples, in both shared and split mode, and compares each output with the shift-and-add formula evaluated in plain integers. A design that truncates the shift logically instead of arithmetically would get negative inputs wrong, and one that wraps instead of clamping would flip sign at both full-scale rails. A design that lets the auxiliary code leak into shared mode, or routes it to the wrong channel in split mode, shows up in the per-channel comparison. Mono routing, pass-through when disabled, and the choice between held and same-cycle capture are each driven with distinct left and right values, so that a swapped or stale sample gives a different number.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int ATTEN_W_DEF  = 6;
    localparam int NUM_CH       = 2;
    localparam int CH_LEFT      = 0;
    localparam int CH_RIGHT     = 1;

    // Fractional step inside one 6 dB octave of attenuation
    typedef enum logic [1:0] {
        STEP_0DB0 = 2'd0,
        STEP_1DB5 = 2'd1,
        STEP_3DB0 = 2'd2,
        STEP_4DB5 = 2'd3
    } frac_step_e;

    typedef struct packed {
        logic [3:0] octave;
        frac_step_e step;
    } atten_code_t;

    function automatic frac_step_e step_of(input logic [1:0] low_bits);
        frac_step_e res;
        case (low_bits)
            2'd0:    res = STEP_0DB0;
            2'd1:    res = STEP_1DB5;
            2'd2:    res = STEP_3DB0;
            default: res = STEP_4DB5;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/lbm_capture_hold.sv
module lbm_capture_hold #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_valid,
    input  logic                       cap_mono,
    input  logic signed [SAMPLE_W-1:0] cap_left,
    input  logic signed [SAMPLE_W-1:0] cap_right,
    output logic signed [SAMPLE_W-1:0] sel_left,
    output logic signed [SAMPLE_W-1:0] sel_right
);

    logic signed [SAMPLE_W-1:0] held_left;
    logic signed [SAMPLE_W-1:0] held_right;
    logic signed [SAMPLE_W-1:0] routed_right;

    // Mono capture: left sample feeds both channels
    assign routed_right = cap_mono ? cap_left : cap_right;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_left  <= '0;
            held_right <= '0;
        end else if (cap_valid) begin
            held_left  <= cap_left;
            held_right <= routed_right;
        end
    end

    // A capture arriving with the playback strobe wins over the held pair
    always_comb begin
        if (cap_valid) begin
            sel_left  = cap_left;
            sel_right = routed_right;
        end else begin
            sel_left  = held_left;
            sel_right = held_right;
        end
    end

endmodule

// File: rtl/lbm_atten.sv
module lbm_atten
    import lbm_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ATTEN_W  = 6
) (
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic        [ATTEN_W-1:0]  code,
    output logic signed [SAMPLE_W:0]   dout
);

    localparam int WIDE_W  = SAMPLE_W + 1;
    localparam int SHIFT_W = ATTEN_W - 2;

    logic        [SHIFT_W-1:0] octave;
    frac_step_e                step;
    logic signed [WIDE_W-1:0]  wide_in;
    logic signed [WIDE_W-1:0]  coarse;

    assign octave  = code[ATTEN_W-1:2];
    assign step    = step_of(code[1:0]);
    assign wide_in = {din[SAMPLE_W-1], din};
    assign coarse  = wide_in >>> octave;

    // Shift-and-add approximation of the sub-octave gain
    always_comb begin
        case (step)
            STEP_0DB0: dout = coarse;
            STEP_1DB5: dout = coarse - (coarse >>> 3) - (coarse >>> 5);
            STEP_3DB0: dout = (coarse >>> 1) + (coarse >>> 3)
                            + (coarse >>> 4) + (coarse >>> 6);
            default:   dout = (coarse >>> 1) + (coarse >>> 4) + (coarse >>> 5);
        endcase
    end

endmodule

// File: rtl/lbm_sat_add.sv
module lbm_sat_add #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] base,
    input  logic signed [SAMPLE_W:0]   addend,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int WIDE_W = SAMPLE_W + 1;
    localparam logic signed [WIDE_W-1:0] POS_FS = WIDE_W'((1 <<< (SAMPLE_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] NEG_FS = -WIDE_W'(1 <<< (SAMPLE_W - 1));

    logic signed [WIDE_W-1:0] total;

    assign total = {base[SAMPLE_W-1], base} + addend;

    always_comb begin
        if (total > POS_FS) begin
            result = POS_FS[SAMPLE_W-1:0];
        end else if (total < NEG_FS) begin
            result = NEG_FS[SAMPLE_W-1:0];
        end else begin
            result = total[SAMPLE_W-1:0];
        end
    end

endmodule

// File: rtl/lbm_loopback_mixer.sv
module lbm_loopback_mixer
    import lbm_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int ATTEN_W  = ATTEN_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_valid,
    input  logic                       cap_mono,
    input  logic signed [SAMPLE_W-1:0] cap_left,
    input  logic signed [SAMPLE_W-1:0] cap_right,
    input  logic                       pb_valid,
    input  logic signed [SAMPLE_W-1:0] pb_left,
    input  logic signed [SAMPLE_W-1:0] pb_right,
    input  logic                       lb_enable,
    input  logic                       split_mode,
    input  logic        [ATTEN_W-1:0]  atten_main,
    input  logic        [ATTEN_W-1:0]  atten_aux,
    output logic                       dac_valid,
    output logic signed [SAMPLE_W-1:0] dac_left,
    output logic signed [SAMPLE_W-1:0] dac_right
);

    logic signed [SAMPLE_W-1:0] cap_sel [NUM_CH];
    logic signed [SAMPLE_W-1:0] pb_arr  [NUM_CH];
    logic        [ATTEN_W-1:0]  code_arr[NUM_CH];
    logic signed [SAMPLE_W:0]   scaled  [NUM_CH];
    logic signed [SAMPLE_W-1:0] mixed   [NUM_CH];
    logic signed [SAMPLE_W-1:0] next_out[NUM_CH];

    lbm_capture_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .cap_mono  (cap_mono),
        .cap_left  (cap_left),
        .cap_right (cap_right),
        .sel_left  (cap_sel[CH_LEFT]),
        .sel_right (cap_sel[CH_RIGHT])
    );

    assign pb_arr[CH_LEFT]    = pb_left;
    assign pb_arr[CH_RIGHT]   = pb_right;
    assign code_arr[CH_LEFT]  = atten_main;
    assign code_arr[CH_RIGHT] = split_mode ? atten_aux : atten_main;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        lbm_atten #(.SAMPLE_W(SAMPLE_W), .ATTEN_W(ATTEN_W)) u_att (
            .din  (cap_sel[ch]),
            .code (code_arr[ch]),
            .dout (scaled[ch])
        );

        lbm_sat_add #(.SAMPLE_W(SAMPLE_W)) u_add (
            .base   (pb_arr[ch]),
            .addend (scaled[ch]),
            .result (mixed[ch])
        );

        // Disabled loopback leaves playback untouched
        assign next_out[ch] = lb_enable ? mixed[ch] : pb_arr[ch];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_valid <= 1'b0;
            dac_left  <= '0;
            dac_right <= '0;
        end else begin
            dac_valid <= pb_valid;
            if (pb_valid) begin
                dac_left  <= next_out[CH_LEFT];
                dac_right <= next_out[CH_RIGHT];
            end
        end
    end

endmodule

// File: rtl/lbm_mixer_checker.sv
module lbm_mixer_checker #(
    parameter int SAMPLE_W = 16,
    parameter int ATTEN_W  = 6
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cap_valid,
    input logic                       cap_mono,
    input logic signed [SAMPLE_W-1:0] cap_left,
    input logic signed [SAMPLE_W-1:0] cap_right,
    input logic                       pb_valid,
    input logic signed [SAMPLE_W-1:0] pb_left,
    input logic signed [SAMPLE_W-1:0] pb_right,
    input logic                       lb_enable,
    input logic                       split_mode,
    input logic        [ATTEN_W-1:0]  atten_main,
    input logic        [ATTEN_W-1:0]  atten_aux,
    input logic                       dac_valid,
    input logic signed [SAMPLE_W-1:0] dac_left,
    input logic signed [SAMPLE_W-1:0] dac_right
);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pb_valid |=> dac_valid); // R2

    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !pb_valid |=> !dac_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pb_valid |=> ($stable(dac_left) && $stable(dac_right))); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (pb_valid && !lb_enable) |=>
        (dac_left == $past(pb_left) && dac_right == $past(pb_right))); // R3

    AST_MONO_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
        (pb_valid && cap_valid && cap_mono && !split_mode && pb_left == pb_right)
        |=> (dac_left == dac_right)); // R8

    AST_SHARED_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
        (pb_valid && cap_valid && !split_mode && pb_left == pb_right
         && cap_left == cap_right) |=> (dac_left == dac_right)); // R6

endmodule

bind lbm_loopback_mixer lbm_mixer_checker #(
    .SAMPLE_W(SAMPLE_W),
    .ATTEN_W (ATTEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cap_valid  (cap_valid),
    .cap_mono   (cap_mono),
    .cap_left   (cap_left),
    .cap_right  (cap_right),
    .pb_valid   (pb_valid),
    .pb_left    (pb_left),
    .pb_right   (pb_right),
    .lb_enable  (lb_enable),
    .split_mode (split_mode),
    .atten_main (atten_main),
    .atten_aux  (atten_aux),
    .dac_valid  (dac_valid),
    .dac_left   (dac_left),
    .dac_right  (dac_right)
);

// File: tb/lbm_loopback_mixer_test.sv
`timescale 1ns/1ps
module lbm_loopback_mixer_test;

    logic               clk = 1'b0;
    logic               rst;
    logic               cap_valid, cap_mono, pb_valid, lb_enable, split_mode;
    logic signed [15:0] cap_left, cap_right, pb_left, pb_right;
    logic        [5:0]  atten_main, atten_aux;
    logic               dac_valid;
    logic signed [15:0] dac_left, dac_right;

    int total = 0;
    int bad   = 0;
    int held_l = 0;
    int held_r = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lbm_loopback_mixer uut (
        .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_mono(cap_mono),
        .cap_left(cap_left), .cap_right(cap_right), .pb_valid(pb_valid),
        .pb_left(pb_left), .pb_right(pb_right), .lb_enable(lb_enable),
        .split_mode(split_mode), .atten_main(atten_main), .atten_aux(atten_aux),
        .dac_valid(dac_valid), .dac_left(dac_left), .dac_right(dac_right)
    );

    function automatic int att_ref(int x, int code);
        int q = code / 4;
        int r = code % 4;
        int s = x >>> q;
        if (r == 0) return s;
        if (r == 1) return s - (s >>> 3) - (s >>> 5);
        if (r == 2) return (s >>> 1) + (s >>> 3) + (s >>> 4) + (s >>> 6);
        return (s >>> 1) + (s >>> 4) + (s >>> 5);
    endfunction

    function automatic int clamp_ref(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One playback sample; called at a falling edge, returns at a falling edge
    task automatic mix_once(input int pl, input int pr, input int cl, input int cr,
                            input bit capv, input bit mono, input bit en,
                            input bit split, input int a, input int b, input string tag);
        int eff_l, eff_r, exp_l, exp_r;
        eff_l = capv ? cl : held_l;
        eff_r = capv ? (mono ? cl : cr) : held_r;
        exp_l = en ? clamp_ref(pl + att_ref(eff_l, a)) : pl;
        exp_r = en ? clamp_ref(pr + att_ref(eff_r, split ? b : a)) : pr;
        if (capv) begin
            held_l = eff_l;
            held_r = eff_r;
        end
        pb_left = 16'(pl); pb_right = 16'(pr);
        cap_left = 16'(cl); cap_right = 16'(cr);
        cap_valid = capv; cap_mono = mono; pb_valid = 1'b1;
        lb_enable = en; split_mode = split;
        atten_main = 6'(a); atten_aux = 6'(b);
        @(negedge clk);
        pb_valid = 1'b0; cap_valid = 1'b0;
        chk(dac_valid == 1'b1, {tag, " R2 strobe"}, int'(dac_valid), 1);
        chk(int'(dac_left) == exp_l, {tag, " left"}, int'(dac_left), exp_l);
        chk(int'(dac_right) == exp_r, {tag, " right"}, int'(dac_right), exp_r);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int caps[6] = '{0, 1, -1, 32767, -32768, -12345};
        int pbs[4]  = '{0, 1000, -20000, 32767};
        int last_l, last_r;
        rst = 1'b1;
        cap_valid = 0; cap_mono = 0; pb_valid = 0; lb_enable = 0; split_mode = 0;
        cap_left = 0; cap_right = 0; pb_left = 0; pb_right = 0;
        atten_main = 0; atten_aux = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dac_valid == 0, "R1 valid", int'(dac_valid), 0);
        chk(dac_left == 0, "R1 left", int'(dac_left), 0);
        chk(dac_right == 0, "R1 right", int'(dac_right), 0);
        rst = 1'b0;
        @(negedge clk);
        // R10 and R1: held pair is zero after reset, code 0 is unity (R5)
        mix_once(1234, -4321, 0, 0, 0, 0, 1, 0, 0, 0, "R10 R1 held zero");

        // R3: disabled pass-through with large capture
        mix_once(-32768, 32767, 32767, -32768, 1, 0, 0, 0, 0, 0, "R3 pass");
        mix_once(555, -777, 20000, 20000, 1, 0, 0, 1, 5, 9, "R3 pass split");

        // R2: outputs hold with no playback strobe
        last_l = dac_left; last_r = dac_right;
        cap_left = 16'sd999; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
        chk(dac_valid == 0, "R2 idle strobe", int'(dac_valid), 0);
        chk(int'(dac_left) == last_l && int'(dac_right) == last_r,
            "R2 idle hold", int'(dac_left), last_l);
        held_l = 999; held_r = 0;

        // R4 R5 R6: shared mode sweep, aux code scrambled
        for (int c = 0; c < 64; c++)
            for (int i = 0; i < 6; i++)
                mix_once(pbs[i % 4], pbs[(i + 1) % 4], caps[i], caps[5 - i],
                         1, 0, 1, 0, c, (c * 37 + 11) % 64, "R4 R5 R6 shared");

        // R7: split mode sweep
        for (int c = 0; c < 64; c++)
            for (int i = 0; i < 6; i++)
                mix_once(pbs[(i + 2) % 4], pbs[i % 4], caps[i], caps[(i + 3) % 6],
                         1, 0, 1, 1, c, 63 - c, "R7 split");

        // R8: mono capture, right input garbage
        for (int c = 0; c < 64; c += 3)
            mix_once(100, -300, -9000, 31000, 1, 1, 1, c % 2, c, (c + 17) % 64, "R8 mono");

        // R9: saturation at both rails
        mix_once(32767, 30000, 32767, 10000, 1, 0, 1, 0, 0, 0, "R9 pos");
        mix_once(-32768, -30000, -32768, -10000, 1, 0, 1, 0, 0, 0, "R9 neg");
        chk(dac_left == -16'sd32768, "R9 neg rail", int'(dac_left), -32768);

        // R10: held pair used, then same-cycle capture overrides
        mix_once(0, 0, 4000, -4000, 1, 0, 1, 0, 0, 0, "R10 load");
        mix_once(10, 20, 0, 0, 0, 0, 1, 1, 4, 8, "R10 held");
        mix_once(10, 20, -2000, 2000, 1, 0, 1, 1, 4, 8, "R10 same cycle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule